// File: doc/BRIEF.md
# Capture Configuration Record Receiver

This block takes a byte stream that carries the setup of a capture engine and loads a set of configuration registers from it. A frame opens with a 32-bit start sync word and closes with a 32-bit end sync word. Between the two sit tagged records. Each record is a 16-bit header followed by a payload, and the payload length is counted in 16-bit words. Every multi-byte quantity arrives least significant byte first.

The receiver hunts for the start sync one byte at a time. Once it finds it, it decodes each header. The variable index is in the upper byte and the word count is in the lower byte. The payload of a known record goes into a staging copy of the matching register: capture mode, clock divider, sample count in units of 16 samples, trigger position, global trigger word or channel enable. Records with an unknown index are skipped by their word count. The 160-word trigger block is checked for its length and skipped.

Only a complete and well-formed frame moves the staged values into the live registers. All six registers change in the same cycle, together with a one-cycle done pulse. A malformed frame raises a one-cycle error pulse instead, leaves the live registers as they were, and sends the receiver back to hunting.

Top module: `cfg_tlv_rx`

## Requirements
- R1: After reset all six live registers read zero, and cfgDone and cfgError are low.
- R2: While no frame is open, bytes are discarded and produce neither cfgDone nor cfgError. This includes an end sync pattern seen at that time. The start sync 0xF5A5F5A5, sent as bytes A5 F5 A5 F5, is recognised at any byte offset, including where it overlaps a partial match.
- R3: A header is the 16-bit little-endian word (index << 8) | wordCount. The known records are:
  - index 0, mode, 1 word
  - index 1, divider, 2 words
  - index 3, sample count, 2 words
  - index 5, trigger position, 2 words
  - index 7, global trigger, 1 word
  - index 8, channel enable, 1 word

  A 2-word payload sends its low 16-bit word first.
- R4: When the final byte of the end sync 0xFA5AFA5A (bytes 5A FA 5A FA) is accepted, cfgDone is high for exactly the next cycle. In that same cycle all live registers show the staged values.
- R5: The live registers do not change while a frame is being received. They change only when the frame completes.
- R6: A header with a known index and the wrong word count raises cfgError in the cycle after its second byte. The live registers keep their previous values and the receiver resumes hunting. Index 64 counts as known and must carry 160 words.
- R7: A pulse on streamEnd while a frame is open raises cfgError in the next cycle and leaves the live registers unchanged. A pulse on streamEnd while hunting has no effect.
- R8: A record whose index is not known is skipped by its word count, including a count of zero. The 160-word trigger block is skipped in the same way. Neither alters any register.
- R9: A register whose record is absent from a completed frame keeps its previous live value.
- R10: The header word 0xFA5A starts the end sync. If the next word is not 0xFA5A, cfgError is raised.
- R11: Cycles with byteValid low are ignored at every point of a frame.
- R12: After cfgDone or cfgError the receiver hunts again, and a following valid frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | byteData holds a stream byte this cycle |
| byteData | input | 8 | Stream byte |
| streamEnd | input | 1 | The transport has ended the stream |
| cfgDone | output | 1 | One-cycle pulse: a frame has been committed |
| cfgError | output | 1 | One-cycle pulse: a frame has been rejected |
| modeWord | output | 16 | Live capture mode word |
| clkDivider | output | 32 | Live clock divider |
| sampleCount | output | 32 | Live sample count, in units of 16 samples |
| trigPosition | output | 32 | Live trigger position |
| trigGlobal | output | 16 | Live global trigger word |
| chanEnable | output | 16 | Live channel enable mask |

## Verification
A wrong internal state shows up on the six live registers and on the two pulses, and it shows up in the cycle right after the decisive byte. A lost byte phase or record count moves later headers off their word boundary. The next frame then fails to complete, or commits with registers from the wrong record. A bad staging path appears as wrong register values at cfgDone. The bench sends many frames with varied contents, optional records and byte gaps, and checks all registers at every commit. It also checks that cfgDone and cfgError appear in exactly the expected cycle.

// File: rtl/cfg_tlv_pkg.sv
package cfg_tlv_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int DWORD_W = 2 * WORD_W;
  localparam int LEN_W = BYTE_W;

  localparam logic [BYTE_W-1:0] IDX_MODE = 8'd0;
  localparam logic [BYTE_W-1:0] IDX_DIV  = 8'd1;
  localparam logic [BYTE_W-1:0] IDX_CNT  = 8'd3;
  localparam logic [BYTE_W-1:0] IDX_TPOS = 8'd5;
  localparam logic [BYTE_W-1:0] IDX_TGLB = 8'd7;
  localparam logic [BYTE_W-1:0] IDX_CHEN = 8'd8;
  localparam logic [BYTE_W-1:0] IDX_TRIG = 8'd64;
  localparam logic [LEN_W-1:0]  LEN_TRIG = 8'd160;

  typedef enum logic [2:0] {
    F_NONE, F_MODE, F_DIV, F_CNT, F_TPOS, F_TGLB, F_CHEN
  } field_e;

  typedef struct packed {
    logic   shiftIn;
    logic   clrWin;
    logic   latchLow;
    logic   frameStart;
    logic   stageWr;
    field_e field;
    logic   wordSel;
    logic   commit;
  } ctl_s;
endpackage

// File: rtl/cfg_tlv_dp.sv
module cfg_tlv_dp
  import cfg_tlv_pkg::*;
#(
  parameter logic [31:0] START_SYNC = 32'hF5A5F5A5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  byteData,
  input  ctl_s               ctl,
  output logic               syncHit,
  output logic [WORD_W-1:0]  curWord,
  output logic [WORD_W-1:0]  liveMode,
  output logic [DWORD_W-1:0] liveDiv,
  output logic [DWORD_W-1:0] liveCnt,
  output logic [DWORD_W-1:0] liveTpos,
  output logic [WORD_W-1:0]  liveTglb,
  output logic [WORD_W-1:0]  liveChen
);
  logic [BYTE_W-1:0]  lowQ;
  logic [DWORD_W-1:0] win;
  logic [DWORD_W-1:0] winNext;
  logic [WORD_W-1:0]  stMode, stTglb, stChen;
  logic [DWORD_W-1:0] stDiv, stCnt, stTpos;

  assign curWord = {byteData, lowQ};
  assign winNext = {byteData, win[DWORD_W-1:BYTE_W]};
  assign syncHit = (winNext == START_SYNC);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowQ <= '0;
      win  <= '0;
    end else begin
      if (ctl.latchLow) lowQ <= byteData;
      if (ctl.clrWin) win <= '0;
      else if (ctl.shiftIn) win <= winNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stMode <= '0; stDiv <= '0; stCnt <= '0;
      stTpos <= '0; stTglb <= '0; stChen <= '0;
    end else if (ctl.frameStart) begin
      stMode <= liveMode; stDiv <= liveDiv; stCnt <= liveCnt;
      stTpos <= liveTpos; stTglb <= liveTglb; stChen <= liveChen;
    end else if (ctl.stageWr) begin
      case (ctl.field)
        F_MODE: stMode <= curWord;
        F_TGLB: stTglb <= curWord;
        F_CHEN: stChen <= curWord;
        F_DIV:  if (ctl.wordSel) stDiv[DWORD_W-1:WORD_W] <= curWord;
                else stDiv[WORD_W-1:0] <= curWord;
        F_CNT:  if (ctl.wordSel) stCnt[DWORD_W-1:WORD_W] <= curWord;
                else stCnt[WORD_W-1:0] <= curWord;
        F_TPOS: if (ctl.wordSel) stTpos[DWORD_W-1:WORD_W] <= curWord;
                else stTpos[WORD_W-1:0] <= curWord;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      liveMode <= '0; liveDiv <= '0; liveCnt <= '0;
      liveTpos <= '0; liveTglb <= '0; liveChen <= '0;
    end else if (ctl.commit) begin
      liveMode <= stMode; liveDiv <= stDiv; liveCnt <= stCnt;
      liveTpos <= stTpos; liveTglb <= stTglb; liveChen <= stChen;
    end
  end

  // R5: live registers move only on a commit strobe
  assert_live_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> ($stable(liveMode) && $stable(liveDiv) && $stable(liveCnt)
                     && $stable(liveTpos) && $stable(liveTglb) && $stable(liveChen)));

  // R6: a frame start and a commit never coincide
  assert_start_commit_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.frameStart && ctl.commit));
endmodule

// File: rtl/cfg_tlv_ctrl.sv
module cfg_tlv_ctrl
  import cfg_tlv_pkg::*;
#(
  parameter logic [31:0] END_SYNC = 32'hFA5AFA5A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic              streamEnd,
  input  logic              syncHit,
  input  logic [WORD_W-1:0] curWord,
  output ctl_s              ctl,
  output logic              cfgDone,
  output logic              cfgError
);
  typedef enum logic [1:0] {S_HUNT, S_HDR, S_PAY, S_ENDW} state_e;

  state_e           state, stNext;
  logic             phase, phN;
  logic [LEN_W-1:0] wordsLeft, wlN, wordNum, wnN;
  field_e           curField, fN;
  logic             doneN, errN;

  logic             hdrKnown;
  logic [LEN_W-1:0] hdrLen, expLen;
  field_e           hdrField;

  assign hdrLen = curWord[LEN_W-1:0];

  always_comb begin
    hdrKnown = 1'b1;
    hdrField = F_NONE;
    expLen   = '0;
    case (curWord[WORD_W-1:LEN_W])
      IDX_MODE: begin hdrField = F_MODE; expLen = 8'd1; end
      IDX_DIV:  begin hdrField = F_DIV;  expLen = 8'd2; end
      IDX_CNT:  begin hdrField = F_CNT;  expLen = 8'd2; end
      IDX_TPOS: begin hdrField = F_TPOS; expLen = 8'd2; end
      IDX_TGLB: begin hdrField = F_TGLB; expLen = 8'd1; end
      IDX_CHEN: begin hdrField = F_CHEN; expLen = 8'd1; end
      IDX_TRIG: begin hdrField = F_NONE; expLen = LEN_TRIG; end
      default:  hdrKnown = 1'b0;
    endcase
  end

  always_comb begin
    ctl    = '0;
    stNext = state;
    phN    = phase;
    wlN    = wordsLeft;
    wnN    = wordNum;
    fN     = curField;
    doneN  = 1'b0;
    errN   = 1'b0;
    if (state != S_HUNT && streamEnd) begin
      errN       = 1'b1;
      stNext     = S_HUNT;
      phN        = 1'b0;
      ctl.clrWin = 1'b1;
    end else if (byteValid) begin
      case (state)
        S_HUNT: begin
          ctl.shiftIn = 1'b1;
          if (syncHit) begin
            stNext         = S_HDR;
            phN            = 1'b0;
            ctl.clrWin     = 1'b1;
            ctl.frameStart = 1'b1;
          end
        end
        S_HDR: begin
          if (!phase) begin
            ctl.latchLow = 1'b1;
            phN          = 1'b1;
          end else begin
            phN = 1'b0;
            if (curWord == END_SYNC[WORD_W-1:0]) begin
              stNext = S_ENDW;
            end else if (hdrKnown && hdrLen != expLen) begin
              errN       = 1'b1;
              stNext     = S_HUNT;
              ctl.clrWin = 1'b1;
            end else if (hdrLen != '0) begin
              stNext = S_PAY;
              wlN    = hdrLen;
              wnN    = '0;
              fN     = hdrField;
            end
          end
        end
        S_PAY: begin
          if (!phase) begin
            ctl.latchLow = 1'b1;
            phN          = 1'b1;
          end else begin
            phN = 1'b0;
            if (curField != F_NONE) begin
              ctl.stageWr = 1'b1;
              ctl.field   = curField;
              ctl.wordSel = wordNum[0];
            end
            wnN = wordNum + 8'd1;
            wlN = wordsLeft - 8'd1;
            if (wordsLeft == 8'd1) stNext = S_HDR;
          end
        end
        default: begin
          if (!phase) begin
            ctl.latchLow = 1'b1;
            phN          = 1'b1;
          end else begin
            phN        = 1'b0;
            stNext     = S_HUNT;
            ctl.clrWin = 1'b1;
            if (curWord == END_SYNC[DWORD_W-1:WORD_W]) begin
              ctl.commit = 1'b1;
              doneN      = 1'b1;
            end else begin
              errN = 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_HUNT;
      phase     <= 1'b0;
      wordsLeft <= '0;
      wordNum   <= '0;
      curField  <= F_NONE;
      cfgDone   <= 1'b0;
      cfgError  <= 1'b0;
    end else begin
      state     <= stNext;
      phase     <= phN;
      wordsLeft <= wlN;
      wordNum   <= wnN;
      curField  <= fN;
      cfgDone   <= doneN;
      cfgError  <= errN;
    end
  end

  // R4: done and error never together
  assert_done_err_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgDone && cfgError));

  // R4: a commit follows only the end-sync state
  assert_done_after_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgDone |-> ($past(state) == S_ENDW));

  // R7: no error can arise while hunting
  assert_no_err_in_hunt_R7: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> ($past(state) != S_HUNT));

  // R11: idle cycles leave the parser position untouched
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !streamEnd) |=> ($stable(state) && $stable(phase) && $stable(wordsLeft)));

  // R12: after a done or error pulse the parser is hunting
  assert_back_to_hunt_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cfgDone || cfgError) |-> (state == S_HUNT));
endmodule

// File: rtl/cfg_tlv_rx.sv
module cfg_tlv_rx
  import cfg_tlv_pkg::*;
#(
  parameter logic [31:0] START_SYNC = 32'hF5A5F5A5,
  parameter logic [31:0] END_SYNC   = 32'hFA5AFA5A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteValid,
  input  logic [BYTE_W-1:0]  byteData,
  input  logic               streamEnd,
  output logic               cfgDone,
  output logic               cfgError,
  output logic [WORD_W-1:0]  modeWord,
  output logic [DWORD_W-1:0] clkDivider,
  output logic [DWORD_W-1:0] sampleCount,
  output logic [DWORD_W-1:0] trigPosition,
  output logic [WORD_W-1:0]  trigGlobal,
  output logic [WORD_W-1:0]  chanEnable
);
  ctl_s              ctl;
  logic              syncHit;
  logic [WORD_W-1:0] curWord;

  cfg_tlv_ctrl #(.END_SYNC(END_SYNC)) ctrl_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .streamEnd(streamEnd),
    .syncHit(syncHit), .curWord(curWord), .ctl(ctl),
    .cfgDone(cfgDone), .cfgError(cfgError)
  );

  cfg_tlv_dp #(.START_SYNC(START_SYNC)) dp_i (
    .clk(clk), .rstN(rstN), .byteData(byteData), .ctl(ctl),
    .syncHit(syncHit), .curWord(curWord),
    .liveMode(modeWord), .liveDiv(clkDivider), .liveCnt(sampleCount),
    .liveTpos(trigPosition), .liveTglb(trigGlobal), .liveChen(chanEnable)
  );
endmodule

// File: tb/cfg_tlv_rx_tb.sv
module cfg_tlv_rx_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        streamEnd = 1'b0;
  logic        cfgDone, cfgError;
  logic [15:0] modeWord, trigGlobal, chanEnable;
  logic [31:0] clkDivider, sampleCount, trigPosition;

  int checks = 0;
  int errors = 0;
  int gap = 0;
  bit finished = 0;

  logic [15:0] eMode, eTglb, eChen;
  logic [31:0] eDiv, eCnt, eTpos;

  cfg_tlv_rx dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .streamEnd(streamEnd), .cfgDone(cfgDone), .cfgError(cfgError),
    .modeWord(modeWord), .clkDivider(clkDivider), .sampleCount(sampleCount),
    .trigPosition(trigPosition), .trigGlobal(trigGlobal), .chanEnable(chanEnable)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkRegs(input string tag);
    check(modeWord == eMode, {tag, " mode"}, 32'(modeWord), 32'(eMode));
    check(clkDivider == eDiv, {tag, " divider"}, clkDivider, eDiv);
    check(sampleCount == eCnt, {tag, " count"}, sampleCount, eCnt);
    check(trigPosition == eTpos, {tag, " trigpos"}, trigPosition, eTpos);
    check(trigGlobal == eTglb, {tag, " trigglb"}, 32'(trigGlobal), 32'(eTglb));
    check(chanEnable == eChen, {tag, " chanen"}, 32'(chanEnable), 32'(eChen));
  endtask

  task automatic putByte(input logic [7:0] b);
    repeat (gap) @(negedge clk);
    byteValid = 1'b1;
    byteData  = b;
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic put16(input logic [15:0] w);
    putByte(w[7:0]);
    putByte(w[15:8]);
  endtask

  task automatic put32(input logic [31:0] d);
    put16(d[15:0]);
    put16(d[31:16]);
  endtask

  task automatic putRec(input logic [7:0] idx, input logic [7:0] len, input logic [31:0] val);
    put16({idx, len});
    for (int k = 0; k < len; k++) begin
      if (k == 0) put16(val[15:0]);
      else if (k == 1) put16(val[31:16]);
      else put16(16'(k * 16'h0101));
    end
  endtask

  task automatic pulseEnd();
    streamEnd = 1'b1;
    @(negedge clk);
    streamEnd = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] m;
    {eMode, eTglb, eChen, eDiv, eCnt, eTpos} = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cfgDone == 0 && cfgError == 0, "R1 pulses low", 32'({cfgDone, cfgError}), 0);
    checkRegs("R1");
    rstN = 1'b1;
    @(negedge clk);

    // R2: garbage incl. end sync and partial sync, then overlapping start
    put32(32'hFA5AFA5A);
    putByte(8'h12); putByte(8'hA5); putByte(8'hF5); putByte(8'hA5);
    check(cfgDone == 0 && cfgError == 0, "R2 garbage ignored", 32'({cfgDone, cfgError}), 0);
    putByte(8'hA5); putByte(8'hF5); putByte(8'hA5); putByte(8'hF5);
    // R3: full frame, all fields
    putRec(8'd0, 8'd1, 32'h0000_9007);
    putRec(8'd1, 8'd2, 32'h1234_5678);
    putRec(8'd3, 8'd2, 32'h0001_0000);
    putRec(8'd5, 8'd2, 32'hCAFE_0040);
    putRec(8'd7, 8'd1, 32'h0000_00F1);
    putRec(8'd8, 8'd1, 32'h0000_FFFF);
    // R5: no change before end sync
    checkRegs("R5 before commit");
    put32(32'hFA5AFA5A);
    check(cfgDone == 1, "R4 done pulse", 32'(cfgDone), 1);
    eMode = 16'h9007; eDiv = 32'h12345678; eCnt = 32'h00010000;
    eTpos = 32'hCAFE0040; eTglb = 16'h00F1; eChen = 16'hFFFF;
    checkRegs("R3 R4 commit");
    @(negedge clk);
    check(cfgDone == 0, "R4 done one cycle", 32'(cfgDone), 0);

    // Sweep: R8 R9 R11 R12
    for (int i = 0; i < 24; i++) begin
      m = 16'((i * 37 + 5) % 64);
      gap = i % 3;
      put32(32'hF5A5F5A5);
      if (i % 6 == 0) begin
        put16({8'd64, 8'd160});
        for (int k = 0; k < 160; k++) put16(16'(k ^ i));
      end
      if (m[0]) begin v = 32'(i * 16'h1357) ^ 32'hA5A5; putRec(8'd0, 8'd1, v); eMode = v[15:0]; end
      if (i % 4 == 1) putRec(8'(9 + i), 8'(i % 3), 32'hDEAD_BEEF);
      if (m[1]) begin v = i * 32'h0101_3131 + 1; putRec(8'd1, 8'd2, v); eDiv = v; end
      if (m[2]) begin v = i * 32'h7777_0123; putRec(8'd3, 8'd2, v); eCnt = v; end
      if (i % 4 == 3) putRec(8'd2, 8'd0, 32'h0);
      if (m[3]) begin v = ~(i * 32'h0F0F_1111); putRec(8'd5, 8'd2, v); eTpos = v; end
      if (m[4]) begin v = 32'(i * 16'h0203); putRec(8'd7, 8'd1, v); eTglb = v[15:0]; end
      if (m[5]) begin v = 32'(16'hFFFF >> (i % 16)); putRec(8'd8, 8'd1, v); eChen = v[15:0]; end
      put32(32'hFA5AFA5A);
      check(cfgDone == 1 && cfgError == 0, $sformatf("R12 R11 sweep %0d done", i), 32'({cfgDone, cfgError}), 32'h2);
      checkRegs($sformatf("R8 R9 sweep %0d", i));
    end
    gap = 0;

    // R6: wrong length on every known index
    for (int f = 0; f < 7; f++) begin
      logic [7:0] idx, len;
      case (f)
        0: begin idx = 0; len = 2; end
        1: begin idx = 1; len = 1; end
        2: begin idx = 3; len = 3; end
        3: begin idx = 5; len = 0; end
        4: begin idx = 7; len = 2; end
        5: begin idx = 8; len = 0; end
        default: begin idx = 64; len = 159; end
      endcase
      put32(32'hF5A5F5A5);
      putRec(8'd0, 8'd1, 32'h0000_1111);
      put16({idx, len});
      check(cfgError == 1, $sformatf("R6 bad length idx %0d", idx), 32'(cfgError), 1);
      put16(16'h0000);
      put32(32'hFA5AFA5A);
      check(cfgDone == 0, "R6 R2 hunting after error", 32'(cfgDone), 0);
      checkRegs("R6 regs kept");
    end

    // R7: stream end while hunting and mid-frame
    pulseEnd();
    check(cfgError == 0, "R7 end while hunting", 32'(cfgError), 0);
    put32(32'hF5A5F5A5);
    putRec(8'd8, 8'd1, 32'h0000_0003);
    pulseEnd();
    check(cfgError == 1, "R7 end mid-frame", 32'(cfgError), 1);
    checkRegs("R7 regs kept");

    // R10: bad second end word
    put32(32'hF5A5F5A5);
    putRec(8'd7, 8'd1, 32'h0000_0777);
    put16(16'hFA5A);
    put16(16'h1234);
    check(cfgError == 1 && cfgDone == 0, "R10 bad end", 32'({cfgDone, cfgError}), 1);
    checkRegs("R10 regs kept");

    // R12: recovery frame
    put32(32'hF5A5F5A5);
    putRec(8'd3, 8'd2, 32'h0000_0400);
    put32(32'hFA5AFA5A);
    eCnt = 32'h400;
    check(cfgDone == 1, "R12 recovery done", 32'(cfgDone), 1);
    checkRegs("R12 recovery");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule